// File: doc/BRIEF.md
# Absolute-Time Alarm Timer

This block keeps a free-running 64-bit time count that advances by one on every system clock, so one time unit is one clock period (100 ns at 10 MHz). Software reads the full count as one snapshot taken in a single cycle. No upper and lower halves are read separately, so no carry can fall between two reads. Software also programs a single alarm as an absolute expiration time rather than a relative interval. The unit raises a sticky interrupt once the count reaches or passes that value.

A flag shows whether an alarm is armed. A new arm request takes over only if it expires strictly earlier than the armed alarm. A request for a later or equal time is refused and reported as not accepted. An expiration that is already in the past is never lost: it fires at the earliest cycle that follows. The all-ones time value means "no alarm" and is always refused. A cancel command drops the alarm and the interrupt. A separate command clears only the interrupt. A kernel can keep its queue of sleeping tasks in software and program only the head of that queue here.

Commands use a request/acknowledge bus. Each cycle with the request high carries one command. The acknowledge, the status bit and the read data come back in the next cycle.

Top module: `abs_alarm_timer`

## Requirements
- R1: After synchronous reset, `alarm_pending`, `alarm_irq` and `bus_ack` are 0 and the time count is 0. A read command issued in the first cycle after reset returns 0.
- R2: The time count rises by exactly one per clock. A read command (`bus_op` = 0) returns in `bus_rdata` the full 64-bit count value held in the cycle the request was sampled. Every command is answered by `bus_ack` = 1 in the following cycle, with `bus_ok` = 1 for all commands except arm.
- R3: An arm command (`bus_op` = 1) with no armed alarm and a value other than all-ones is accepted. `bus_ok` is 1, and `alarm_pending` reads 1 in the cycle after the request.
- R4: When the count equals or exceeds the armed expiration T, `alarm_irq` is set and `alarm_pending` is cleared by the same clock edge, which is the edge at which the count held T.
- R5: An expiration that is not later than the count when it is armed is accepted. The pending flag is set on the arm edge, and the interrupt fires on the next edge.
- R6: An arm command whose time is strictly earlier than the armed expiration replaces it (`bus_ok` = 1). The alarm then fires at the new time.
- R7: An arm command whose time is later than or equal to the armed expiration is refused (`bus_ok` = 0). The armed alarm still fires at its original time.
- R8: An arm command with the all-ones value is refused (`bus_ok` = 0) and changes neither the pending flag nor an armed expiration.
- R9: A cancel command (`bus_op` = 2) clears `alarm_pending` and `alarm_irq`. The time count is left unchanged, and the cancelled alarm never fires.
- R10: `alarm_irq` stays at 1 until a clear command (`bus_op` = 3) or a cancel. The clear command leaves `alarm_pending` untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one time unit per period |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Command valid for this cycle |
| bus_op | input | 2 | Command: 0 read time, 1 arm, 2 cancel, 3 clear interrupt |
| bus_wdata | input | 64 | Absolute expiration time for arm |
| bus_ack | output | 1 | Command completed (cycle after request) |
| bus_ok | output | 1 | Arm accepted; 1 for other commands |
| bus_rdata | output | 64 | Time snapshot for read, 0 otherwise |
| alarm_pending | output | 1 | An alarm is armed and not yet fired |
| alarm_irq | output | 1 | Sticky alarm interrupt |

## Verification
Each bus result (acknowledge, status bit, time snapshot) is due one cycle after its request. The bench records the expected item in a queue when it drives the request. A monitor pops that item on the falling edge where the acknowledge shows. The pending flag is due one edge after an arm or cancel. The interrupt for a future time T is due at the first falling edge at which the bench's own count of post-reset edges equals T+1, and it must still be low one sample earlier. A past time fires exactly two samples after the request was driven. All samples are taken on falling edges, so each result is read between the edge that produced it and the next one.

// File: rtl/alarm_pkg.sv
// Shared command encoding for the absolute-time alarm timer.
// Assumes a 2-bit command field on the request bus.
package alarm_pkg;

    typedef enum logic [1:0] {
        CMD_READ   = 2'd0,
        CMD_ARM    = 2'd1,
        CMD_CANCEL = 2'd2,
        CMD_IRQCLR = 2'd3
    } alarm_cmd_e;

endpackage

// File: rtl/mono_time_ctr.sv
// Free-running monotonic time counter, one increment per clock.
// Assumes the count never wraps in service (64 bits at tens of MHz).
module mono_time_ctr #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TIME_W-1:0] now
);

    logic [TIME_W-1:0] count_q;

    // Advance time by one unit per clock; zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_q + 1'b1;
    end

    assign now = count_q;

    AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> count_q == $past(count_q) + 1'b1); // R2

endmodule

// File: rtl/alarm_slot.sv
// Single absolute alarm: holds one expiration time, fires a sticky interrupt
// when the time count reaches it, and lets only an earlier request replace it.
// Assumes at most one strobe is active per cycle.
module alarm_slot #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now,
    input  logic              arm_stb,
    input  logic              cancel_stb,
    input  logic              irqclr_stb,
    input  logic [TIME_W-1:0] arm_time,
    output logic              accept,
    output logic              pending,
    output logic              irq
);

    localparam logic [TIME_W-1:0] NO_ALARM = {TIME_W{1'b1}};

    logic [TIME_W-1:0] expiry_q;
    logic              pending_q;
    logic              irq_q;
    logic              fire;
    logic              live;

    // Expiry reached: the count has met or passed the armed time.
    always_comb fire = pending_q && (now >= expiry_q);

    // An alarm still counts as armed only if it is not firing right now.
    always_comb live = pending_q && !fire;

    // Accept a real time that is strictly earlier, or anything when idle.
    always_comb accept = arm_stb && (arm_time != NO_ALARM) &&
                         (!live || (arm_time < expiry_q));

    // Update the pending flag, the expiration register and the sticky interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expiry_q  <= NO_ALARM;
            pending_q <= 1'b0;
            irq_q     <= 1'b0;
        end else if (cancel_stb) begin
            pending_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (irqclr_stb) irq_q <= 1'b0;
            if (fire) begin
                pending_q <= 1'b0;
                irq_q     <= 1'b1;
            end
            if (accept) begin
                pending_q <= 1'b1;
                expiry_q  <= arm_time;
            end
        end
    end

    assign pending = pending_q;
    assign irq     = irq_q;

    AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pending_q && (now >= expiry_q) && !arm_stb && !cancel_stb
        |=> irq_q && !pending_q); // R4

    AST_ARMED_NOT_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        pending_q |-> expiry_q != NO_ALARM); // R8

    AST_NONE_KEEPS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        arm_stb && (arm_time == NO_ALARM) |=> $stable(expiry_q)); // R8

    AST_LATER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        arm_stb && pending_q && (now < expiry_q) && (arm_time >= expiry_q)
        |=> $stable(expiry_q) && pending_q); // R7

    AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_stb |=> !pending_q && !irq_q); // R9

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q && !irqclr_stb && !cancel_stb |=> irq_q); // R10

endmodule

// File: rtl/alarm_bus_if.sv
// Request/acknowledge command port: decodes the command into strobes and
// registers the acknowledge, status bit and time snapshot for the next cycle.
// Assumes every cycle with the request high is one separate command.
module alarm_bus_if #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [1:0]        op,
    input  logic [TIME_W-1:0] now,
    input  logic              accept,
    output logic              arm_stb,
    output logic              cancel_stb,
    output logic              irqclr_stb,
    output logic              ack,
    output logic              ok,
    output logic [TIME_W-1:0] rdata
);

    import alarm_pkg::*;

    alarm_cmd_e cmd;

    // Interpret the command field.
    always_comb cmd = alarm_cmd_e'(op);

    // Raise one strobe for the command being issued this cycle.
    always_comb begin
        arm_stb    = req && (cmd == CMD_ARM);
        cancel_stb = req && (cmd == CMD_CANCEL);
        irqclr_stb = req && (cmd == CMD_IRQCLR);
    end

    // Register the response so it appears in the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            ok    <= 1'b0;
            rdata <= '0;
        end else begin
            ack <= req;
            if (req) begin
                ok    <= (cmd == CMD_ARM) ? accept : 1'b1;
                rdata <= (cmd == CMD_READ) ? now : '0;
            end
        end
    end

    AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ack); // R2

    AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        req && (cmd == CMD_READ) |=> rdata == $past(now)); // R2

endmodule

// File: rtl/abs_alarm_timer.sv
// Top level of the absolute-time alarm timer: monotonic time count, one
// closer-wins alarm slot and the command port.
// Assumes a single clock domain and synchronous active-low reset.
module abs_alarm_timer #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic [1:0]        bus_op,
    input  logic [TIME_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic              bus_ok,
    output logic [TIME_W-1:0] bus_rdata,
    output logic              alarm_pending,
    output logic              alarm_irq
);

    logic [TIME_W-1:0] now;
    logic              arm_stb;
    logic              cancel_stb;
    logic              irqclr_stb;
    logic              accept;

    mono_time_ctr #(.TIME_W(TIME_W)) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .now   (now)
    );

    alarm_bus_if #(.TIME_W(TIME_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (bus_req),
        .op         (bus_op),
        .now        (now),
        .accept     (accept),
        .arm_stb    (arm_stb),
        .cancel_stb (cancel_stb),
        .irqclr_stb (irqclr_stb),
        .ack        (bus_ack),
        .ok         (bus_ok),
        .rdata      (bus_rdata)
    );

    alarm_slot #(.TIME_W(TIME_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .now        (now),
        .arm_stb    (arm_stb),
        .cancel_stb (cancel_stb),
        .irqclr_stb (irqclr_stb),
        .arm_time   (bus_wdata),
        .accept     (accept),
        .pending    (alarm_pending),
        .irq        (alarm_irq)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !alarm_pending && !alarm_irq && !bus_ack); // R1

endmodule

// File: tb/abs_alarm_timer_tb_top.sv
`timescale 1ns/1ps
module abs_alarm_timer_tb_top;

    localparam int TW = 64;
    localparam logic [TW-1:0] ONES = {TW{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic [1:0]    bus_op = 2'd0;
    logic [TW-1:0] bus_wdata = '0;
    logic          bus_ack, bus_ok, alarm_pending, alarm_irq;
    logic [TW-1:0] bus_rdata;

    always #2 clk = ~clk;

    abs_alarm_timer #(.TIME_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_op(bus_op),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_ok(bus_ok),
        .bus_rdata(bus_rdata), .alarm_pending(alarm_pending), .alarm_irq(alarm_irq)
    );

    // Reference time: edges seen since reset release.
    logic [TW-1:0] tb_time = '0;
    always @(posedge clk) begin
        if (!rst_n) tb_time <= '0;
        else        tb_time <= tb_time + 1'b1;
    end

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic [1:0]    op;
        logic [TW-1:0] exp_rdata;
        logic          exp_ok;
        string         tag;
    } exp_t;
    exp_t sb[$];

    task automatic check(input bit cond, input string tag,
                         input logic [TW-1:0] act, input logic [TW-1:0] exp);
        n_run++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop one expected item per acknowledge and compare.
    always @(negedge clk) begin
        if (rst_n && bus_ack) begin
            if (sb.size() == 0) begin
                check(0, "R2 unexpected ack", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(bus_ok == e.exp_ok, {e.tag, " ok"}, bus_ok, e.exp_ok);
                if (e.op == 2'd0)
                    check(bus_rdata == e.exp_rdata, {e.tag, " rdata"}, bus_rdata, e.exp_rdata);
            end
        end
    end

    // Driver: called on a falling edge, issues one command for one cycle.
    task automatic cmd(input logic [1:0] op, input logic [TW-1:0] wd,
                       input logic exp_ok, input string tag);
        exp_t e;
        e.op = op; e.exp_rdata = tb_time; e.exp_ok = exp_ok; e.tag = tag;
        sb.push_back(e);
        bus_req = 1'b1; bus_op = op; bus_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_op = 2'd0; bus_wdata = '0;
    endtask

    task automatic wait_until(input logic [TW-1:0] t);
        while (tb_time != t) @(negedge clk);
    endtask

    // Expect alarm firing at absolute time t: low at sample t, high at t+1.
    task automatic expect_fire(input logic [TW-1:0] t, input string tag);
        wait_until(t);
        check(alarm_irq == 1'b0, {tag, " irq early"}, alarm_irq, 0);
        check(alarm_pending == 1'b1, {tag, " pending before"}, alarm_pending, 1);
        @(negedge clk);
        check(alarm_irq == 1'b1, {tag, " irq at expiry"}, alarm_irq, 1);
        check(alarm_pending == 1'b0, {tag, " pending after"}, alarm_pending, 0);
    endtask

    initial begin
        logic [TW-1:0] t;
        repeat (5) @(negedge clk);
        check(alarm_pending == 0, "R1 pending", alarm_pending, 0);
        check(alarm_irq == 0, "R1 irq", alarm_irq, 0);
        check(bus_ack == 0, "R1 ack", bus_ack, 0);
        rst_n = 1'b1;
        cmd(2'd0, '0, 1, "R1 first read");
        // R2: back-to-back reads give consecutive snapshots
        cmd(2'd0, '0, 1, "R2 read a");
        cmd(2'd0, '0, 1, "R2 read b");
        repeat (7) @(negedge clk);
        cmd(2'd0, '0, 1, "R2 read c");

        // R3 + R4: arm a future time
        t = tb_time + 20;
        cmd(2'd1, t, 1, "R3 arm");
        check(alarm_pending == 1, "R3 pending set", alarm_pending, 1);
        expect_fire(t, "R4");
        // R10: sticky until clear
        repeat (5) @(negedge clk);
        check(alarm_irq == 1, "R10 sticky", alarm_irq, 1);
        cmd(2'd3, '0, 1, "R10 clear");
        check(alarm_irq == 0, "R10 cleared", alarm_irq, 0);

        // R5: past expiration fires on the next edge
        t = tb_time - 3;
        cmd(2'd1, t, 1, "R5 arm past");
        check(alarm_pending == 1 && alarm_irq == 0, "R5 armed", {alarm_pending, alarm_irq}, 2);
        @(negedge clk);
        check(alarm_irq == 1 && alarm_pending == 0, "R5 fired", {alarm_pending, alarm_irq}, 1);
        cmd(2'd3, '0, 1, "R10 clear b");

        // R6: earlier request replaces
        cmd(2'd1, tb_time + 100, 1, "R6 arm far");
        t = tb_time + 40;
        cmd(2'd1, t, 1, "R6 arm near");
        expect_fire(t, "R6");
        cmd(2'd3, '0, 1, "R10 clear c");

        // R7: later or equal refused
        t = tb_time + 30;
        cmd(2'd1, t, 1, "R7 arm");
        cmd(2'd1, t + 50, 0, "R7 later");
        cmd(2'd1, t, 0, "R7 equal");
        expect_fire(t, "R7");
        cmd(2'd3, '0, 1, "R10 clear d");

        // R8: all-ones never arms
        cmd(2'd1, ONES, 0, "R8 none idle");
        check(alarm_pending == 0, "R8 idle stays", alarm_pending, 0);
        t = tb_time + 25;
        cmd(2'd1, t, 1, "R8 arm");
        cmd(2'd1, ONES, 0, "R8 none armed");
        expect_fire(t, "R8");

        // R9: cancel clears irq and pending, time unaffected
        cmd(2'd2, '0, 1, "R9 cancel irq");
        check(alarm_irq == 0, "R9 irq cleared", alarm_irq, 0);
        t = tb_time + 200;
        cmd(2'd1, t, 1, "R9 arm");
        cmd(2'd2, '0, 1, "R9 cancel");
        check(alarm_pending == 0, "R9 pending cleared", alarm_pending, 0);
        cmd(2'd0, '0, 1, "R9 time continues");
        wait_until(t + 3);
        check(alarm_irq == 0, "R9 never fires", alarm_irq, 0);

        // R10: clear leaves pending alone
        cmd(2'd1, tb_time - 1, 1, "R10 arm past");
        @(negedge clk);
        cmd(2'd1, tb_time + 50, 1, "R10 rearm");
        cmd(2'd3, '0, 1, "R10 clear keeps");
        check(alarm_irq == 0 && alarm_pending == 1, "R10 pending kept",
              {alarm_pending, alarm_irq}, 2);

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R2 all acked", sb.size(), 0);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule